// File: doc/BRIEF.md
# Intermediate Layer Picker for a Stacked Mesh

This block sits beside the injection port of one node in a three-dimensional mesh network. For every packet the node is about to send, it proposes the vertical layer the packet first travels to before it turns onto the horizontal routes. The choice comes from a pseudo-random register whose width is the base-2 logarithm of the total node count. At reset this register is loaded from the node's own address, so neighbouring nodes run through different sequences. The proposed layer is that register's value reduced modulo the layer count.

The layer is offered on a registered output one cycle ahead of use. The injection logic reads `layer_o`, writes it into the packet header, and pulses `pkt_acc_i` in the cycle the packet is taken. The register advances exactly once for each accepted packet and never per flit, so every flit of a packet follows the same route. When the destination column and row match this node's own, a detour through another layer would only create a loop. In that case the proposal is replaced by the destination's layer. This forced choice does not disturb the random sequence.

Top module: `layer_pick`

## Requirements
- R1: While reset is asserted, and until the first accept, `layer_o` equals the seed modulo `Z_DIM`, where the seed is `NODE_ID` truncated to the register width.
- R2: A seed of zero is replaced by 1, so the register never holds zero. With `NODE_ID`=0 the reset layer is 1, and after one accept it is 2.
- R3: When the override is not active, `layer_o` equals the register state modulo `Z_DIM`. That is the low two bits for four layers, and it is always below `Z_DIM`.
- R4: Each cycle with `pkt_acc_i` high advances the 8-bit register one Fibonacci step for x^8+x^6+x^5+x^4+1. The value shifts toward the MSB and the new bit 0 is b7^b5^b4^b3. Without an accept the register, and therefore the non-forced layer, holds.
- R5: If `dst_x_i`==`src_x_i` and `dst_y_i`==`src_y_i`, then `layer_o` in the next cycle equals that cycle's `dst_z_i`. The register still advances or holds by R4 alone.
- R6: `layer_o` is registered. After a clock edge it reflects the destination inputs sampled at that edge and the register state after that edge's accept.
- R7: The register repeats every 255 accepts. Over one full period with four layers, layer 0 is offered 63 times and layers 1, 2 and 3 are each offered 64 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_acc_i | input | 1 | One-cycle strobe: the packet using the current `layer_o` is taken |
| src_x_i | input | XW | This node's column |
| src_y_i | input | YW | This node's row |
| dst_x_i | input | XW | Next packet's destination column |
| dst_y_i | input | YW | Next packet's destination row |
| dst_z_i | input | ZW | Next packet's destination layer |
| layer_o | output | ZW | Proposed intermediate layer for the next packet |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. The inputs present at an edge, including the accept strobe, set `layer_o` just after that edge. The driver applies inputs at the falling edge and pushes the value expected after the next rising edge. The monitor pops and compares 1 ns after each rising edge, so each expectation meets the output one register stage later. The reset value is read while reset is still held. A full 255-accept period is counted on the output to check the per-layer totals.

// File: rtl/layer_pick_pkg.sv
package layer_pick_pkg;

  // Feedback mask (bit i set => stage i+1 tapped) of a maximal Fibonacci polynomial
  function automatic logic [31:0] tap_mask(input int w);
    case (w)
      2:       return 32'h0000_0003;
      3:       return 32'h0000_0006;
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0829;
      13:      return 32'h0000_100D;
      14:      return 32'h0000_2015;
      15:      return 32'h0000_6000;
      16:      return 32'h0000_D008;
      default: return 32'h0000_00B8;
    endcase
  endfunction

  function automatic int fix_seed(input int seed, input int w);
    int s;
    s = seed % (1 << w);
    return (s == 0) ? 1 : s;
  endfunction

  function automatic int bits_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/layer_pick_lfsr.sv
module layer_pick_lfsr
  import layer_pick_pkg::*;
#(
  parameter int W    = 8,
  parameter int SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);
  localparam logic [31:0]  MASK32 = tap_mask(W);
  localparam logic [W-1:0] MASK   = MASK32[W-1:0];
  localparam logic [31:0]  SEED32 = 32'(fix_seed(SEED, W));
  localparam logic [W-1:0] INIT   = SEED32[W-1:0];

  logic [W-1:0] state_q;
  logic [W-1:0] stepped;
  logic         fb;

  assign fb      = ^(state_q & MASK);
  assign stepped = {state_q[W-2:0], fb};
  assign next_o  = step_i ? stepped : state_q;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= INIT;
    else         state_q <= next_o;
  end
endmodule

// File: rtl/layer_pick_mod.sv
module layer_pick_mod #(
  parameter int W   = 8,
  parameter int NUM = 4,
  parameter int OW  = 2
) (
  input  logic [W-1:0]  val_i,
  output logic [OW-1:0] res_o
);
  localparam bit POW2 = (NUM & (NUM - 1)) == 0;

  generate
    if (POW2 && NUM > 1) begin : g_slice
      assign res_o = val_i[OW-1:0];
    end else if (NUM <= 1) begin : g_one
      assign res_o = '0;
    end else begin : g_rem
      logic [W-1:0] rem;
      assign rem   = val_i % W'(NUM);
      assign res_o = rem[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/layer_pick_ovr.sv
module layer_pick_ovr #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 2
) (
  input  logic [XW-1:0] src_x_i,
  input  logic [YW-1:0] src_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [ZW-1:0] dst_z_i,
  input  logic [ZW-1:0] rand_i,
  output logic [ZW-1:0] layer_o
);
  logic same_col;
  assign same_col = (src_x_i == dst_x_i) && (src_y_i == dst_y_i);
  // going to another layer and back would loop
  assign layer_o  = same_col ? dst_z_i : rand_i;
endmodule

// File: rtl/layer_pick.sv
module layer_pick
  import layer_pick_pkg::*;
#(
  parameter int X_DIM   = 8,
  parameter int Y_DIM   = 8,
  parameter int Z_DIM   = 4,
  parameter int NODE_ID = 1,
  parameter int XW      = bits_for(X_DIM),
  parameter int YW      = bits_for(Y_DIM),
  parameter int ZW      = bits_for(Z_DIM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pkt_acc_i,
  input  logic [XW-1:0] src_x_i,
  input  logic [YW-1:0] src_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [ZW-1:0] dst_z_i,
  output logic [ZW-1:0] layer_o
);
  localparam int          NODES     = X_DIM * Y_DIM * Z_DIM;
  localparam int          LW        = bits_for(NODES);
  localparam int          SEED_FIX  = fix_seed(NODE_ID, LW);
  localparam logic [31:0] RST_LAY32 = 32'(SEED_FIX % Z_DIM);
  localparam logic [ZW-1:0] RST_LAYER = RST_LAY32[ZW-1:0];

  logic [LW-1:0] lfsr_q;
  logic [LW-1:0] lfsr_next;
  logic [ZW-1:0] rand_layer;
  logic [ZW-1:0] layer_d;
  logic [ZW-1:0] layer_q;

  layer_pick_lfsr #(.W(LW), .SEED(NODE_ID)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (pkt_acc_i),
    .state_o(lfsr_q),
    .next_o (lfsr_next)
  );

  // reduce the post-accept state so the output is ready a cycle early
  layer_pick_mod #(.W(LW), .NUM(Z_DIM), .OW(ZW)) u_mod (
    .val_i(lfsr_next),
    .res_o(rand_layer)
  );

  layer_pick_ovr #(.XW(XW), .YW(YW), .ZW(ZW)) u_ovr (
    .src_x_i(src_x_i),
    .src_y_i(src_y_i),
    .dst_x_i(dst_x_i),
    .dst_y_i(dst_y_i),
    .dst_z_i(dst_z_i),
    .rand_i (rand_layer),
    .layer_o(layer_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) layer_q <= RST_LAYER;
    else         layer_q <= layer_d;
  end

  assign layer_o = layer_q;
endmodule

// File: rtl/layer_pick_chk.sv
module layer_pick_chk #(
  parameter int Z_DIM = 4,
  parameter int XW    = 3,
  parameter int YW    = 3,
  parameter int ZW    = 2,
  parameter int LW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pkt_acc_i,
  input logic [XW-1:0] src_x_i,
  input logic [YW-1:0] src_y_i,
  input logic [XW-1:0] dst_x_i,
  input logic [YW-1:0] dst_y_i,
  input logic [ZW-1:0] dst_z_i,
  input logic [ZW-1:0] layer_o,
  input logic [LW-1:0] lfsr_i
);
  logic armed_q;
  logic match;

  assign match = (src_x_i == dst_x_i) && (src_y_i == dst_y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != '0);

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(layer_o) < Z_DIM);

  p_rand_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !$past(match) |-> 32'(layer_o) == 32'(lfsr_i) % Z_DIM);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_acc_i |=> $stable(lfsr_i));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_acc_i |=> lfsr_i == {$past(lfsr_i[LW-2:0]),
                             ^($past(lfsr_i) & LW'(8'hB8))});

  p_force_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(match) |-> layer_o == $past(dst_z_i));
endmodule

bind layer_pick layer_pick_chk #(
  .Z_DIM(Z_DIM), .XW(XW), .YW(YW), .ZW(ZW), .LW(LW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pkt_acc_i(pkt_acc_i),
  .src_x_i  (src_x_i),
  .src_y_i  (src_y_i),
  .dst_x_i  (dst_x_i),
  .dst_y_i  (dst_y_i),
  .dst_z_i  (dst_z_i),
  .layer_o  (layer_o),
  .lfsr_i   (lfsr_q)
);

// File: tb/layer_pick_tb_top.sv
`timescale 1ns/1ps
module layer_pick_tb_top;
  localparam int SRC_X = 2;
  localparam int SRC_Y = 3;

  typedef struct {
    logic [1:0] exp_a;
    logic [1:0] exp_b;
    bit         cnt;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc = 1'b0;
  logic [2:0] dx = 3'd0;
  logic [2:0] dy = 3'd0;
  logic [1:0] dz = 2'd0;
  logic [1:0] lay_a, lay_b;

  int checks = 0;
  int errors = 0;
  int hist[4];
  logic [7:0] ma, mb;
  item_t q[$];

  always #2.5 clk = ~clk;

  layer_pick #(.NODE_ID(8'h5A)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pkt_acc_i(acc),
    .src_x_i(3'(SRC_X)), .src_y_i(3'(SRC_Y)),
    .dst_x_i(dx), .dst_y_i(dy), .dst_z_i(dz), .layer_o(lay_a));

  layer_pick #(.NODE_ID(0)) dut_zero_i (
    .clk_i(clk), .rst_ni(rst_n), .pkt_acc_i(acc),
    .src_x_i(3'(SRC_X)), .src_y_i(3'(SRC_Y)),
    .dst_x_i(dx), .dst_y_i(dy), .dst_z_i(dz), .layer_o(lay_b));

  function automatic logic [7:0] step8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit a, input int x, input int y, input int z,
                       input string req, input bit cnt);
    item_t it;
    bit forced;
    @(negedge clk);
    acc = a; dx = 3'(x); dy = 3'(y); dz = 2'(z);
    if (a) begin
      ma = step8(ma);
      mb = step8(mb);
    end
    forced   = (x == SRC_X) && (y == SRC_Y);
    it.exp_a = forced ? 2'(z) : ma[1:0];
    it.exp_b = forced ? 2'(z) : mb[1:0];
    it.cnt   = cnt;
    it.req   = req;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.req, " node5A"}, int'(lay_a), int'(it.exp_a));
        check({it.req, " node0"},  int'(lay_b), int'(it.exp_b));
        if (it.cnt) hist[lay_a]++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ma = 8'h5A;
    mb = 8'h01;
    foreach (hist[i]) hist[i] = 0;
    dx = 3'd5; dy = 3'd5;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset layer", int'(lay_a), 2);   // 0x5A mod 4
    check("R2 zero seed",   int'(lay_b), 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 hold: no accept, layer stays
    for (int i = 0; i < 5; i++) drive(0, i, 7, i % 4, "R4 hold", 0);
    // R2: first step of zero-seeded node gives 2
    drive(1, 6, 1, 0, "R2 first step", 0);
    // R3/R6 back-to-back accepts with changing destinations
    for (int i = 0; i < 20; i++) drive(1, (i * 3) % 8, 7 - (i % 8), i % 4, "R3 R6 accept", 0);
    // R6 sparse accepts
    for (int i = 0; i < 20; i++) drive(i % 3 == 0, 0, i % 8, 3, "R6 sparse", 0);
    // R5 override, with and without accept; sequence must stay intact
    for (int i = 0; i < 16; i++) drive(i % 2, SRC_X, SRC_Y, i % 4, "R5 forced", 0);
    drive(1, SRC_X, 0, 1, "R5 only x", 0);
    drive(1, 0, SRC_Y, 1, "R5 only y", 0);
    for (int i = 0; i < 6; i++) drive(1, 7, 7, 0, "R5 after", 0);
    // R7 full period
    for (int i = 0; i < 255; i++) drive(1, 1, 1, 0, "R7 period", 1);
    drive(0, 1, 1, 0, "R7 tail", 0);
    drive(0, 1, 1, 0, "R7 tail", 0);
    @(posedge clk); #2;
    check("R7 count layer0", hist[0], 63);
    check("R7 count layer1", hist[1], 64);
    check("R7 count layer2", hist[2], 64);
    check("R7 count layer3", hist[3], 64);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule